// File: doc/BRIEF.md
# Dual-Mode 16-bit Pulse Accumulator

This block counts activity on a single external pin in one of two modes. In event mode it adds one to a 16-bit count for each pin edge of a chosen polarity. In gated mode it adds one for each divide-by-64 tick from the timebase, but only while the pin sits at a chosen active level. The pin is synchronized inside the block before any edge detection. The count can therefore lag a pin change by a few bus clocks, and a pulse must last longer than two bus clocks to be seen.

Two sticky flags record events. The wrap flag sets when the count rolls over from all ones to zero. The input flag sets on each counted edge in event mode, and on the trailing edge of the gate in gated mode. Each flag is cleared by writing a one to its bit. When fast clear is on, any read or write of the count clears both flags. Each flag is ANDed with its own enable to form an active-high interrupt request.

The block has its own enable, separate from the main timer enable. With the timer disabled, event mode still counts, but gated mode receives no ticks. The block also outputs a one-cycle pulse for every increment, which the timebase can select as a clock source. Register decoding is done outside this block.

Top module: `pacc_top`

## Requirements
- R1: After reset the count is 0x0000, both flags are 0 and both interrupt requests are 0.
- R2: While the accumulator enable is 0, pin edges and ticks change neither the count nor the flags.
- R3: In event mode (mode bit 0) with polarity 1, each rising pin edge adds one to the count and sets the input flag. Falling edges are not counted.
- R4: In event mode with polarity 0, each falling pin edge adds one to the count and sets the input flag. Rising edges are not counted.
- R5: In gated mode (mode bit 1) with polarity 0, each tick adds one while the pin is high. The falling edge that ends the gate sets the input flag, and the rising edge that opens it does not.
- R6: In gated mode with polarity 1, each tick adds one while the pin is low. The rising edge that ends the gate sets the input flag.
- R7: In gated mode, ticks are ignored while the main timer enable is 0.
- R8: An increment from 0xFFFF gives 0x0000 and sets the wrap flag.
- R9: A flag write with bit 1 set clears the wrap flag, and one with bit 0 set clears the input flag. Zero bits leave their flag unchanged.
- R10: With fast clear set, a count read or a count write clears both flags. With fast clear off, a count read leaves the flags unchanged.
- R11: A count write loads the written value, and it takes priority over an increment in the same cycle.
- R12: Each interrupt request equals its flag ANDed with its enable.
- R13: The clock output pulses for exactly one bus clock per increment of the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously and released synchronously to clk |
| pin_i | input | 1 | Asynchronous channel pin |
| tick64_i | input | 1 | One-cycle divide-by-64 tick from the timebase |
| tmr_en_i | input | 1 | Main timer enable; when 0, ticks are not passed to gated mode |
| acc_en_i | input | 1 | Accumulator enable |
| mode_i | input | 1 | 0 = event mode, 1 = gated mode |
| pol_i | input | 1 | Edge or level polarity select |
| ovf_ie_i | input | 1 | Wrap interrupt enable |
| inp_ie_i | input | 1 | Input interrupt enable |
| fast_clr_i | input | 1 | Clear both flags on any count access |
| cnt_rd_i | input | 1 | Count read strobe |
| cnt_wr_i | input | 1 | Count write strobe |
| cnt_wdata_i | input | 16 | Count write data |
| flg_wr_i | input | 1 | Flag write strobe |
| flg_wdata_i | input | 2 | Flag write data: bit 1 = wrap, bit 0 = input |
| cnt_o | output | 16 | Current count |
| ovf_flag_o | output | 1 | Wrap flag |
| inp_flag_o | output | 1 | Input flag |
| ovf_irq_o | output | 1 | Wrap interrupt request |
| inp_irq_o | output | 1 | Input interrupt request |
| paclk_o | output | 1 | One-cycle pulse per increment, for use by the timebase |

## Verification
A wrong synchronizer or edge-select state shows up as a count that differs from the number of qualifying edges. The difference is visible at the count port three bus clocks after the pin changes, and it stays there because the count has no other path back. A wrong gate level shows in two ways: ticks counted while the pin is idle, or the input flag rising when the gate opens rather than when it closes. The sweeps drive every mode and polarity pair with several pulse or tick counts, so a single wrong edge or tick shows up as a count that is off by one. Wrap, flag-clear and write-priority faults show at the flag and count ports one clock after the triggering cycle.

// File: rtl/pacc_pkg.sv
package pacc_pkg;
  typedef enum logic {
    MODE_EVENT = 1'b0,
    MODE_GATED = 1'b1
  } pacc_mode_e;

  localparam int FLG_W   = 2;
  localparam int FLG_OVF = 1;
  localparam int FLG_INP = 0;
endpackage

// File: rtl/pacc_sync.sv
module pacc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] sr_q;
  logic              prev_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      logic din;
      if (g == 0) begin : g_first
        assign din = d_i;
      end else begin : g_next
        assign din = sr_q[g-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q[g] <= 1'b0;
        else        sr_q[g] <= din;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sr_q[LAST];
  end

  assign lvl_o  = sr_q[LAST];
  assign rise_o = sr_q[LAST] & ~prev_q;
  assign fall_o = ~sr_q[LAST] & prev_q;
endmodule

// File: rtl/pacc_qual.sv
module pacc_qual
  import pacc_pkg::*;
(
  input  logic       acc_en_i,
  input  pacc_mode_e mode_i,
  input  logic       pol_i,
  input  logic       tmr_en_i,
  input  logic       tick64_i,
  input  logic       lvl_i,
  input  logic       rise_i,
  input  logic       fall_i,
  output logic       inc_o,
  output logic       inp_evt_o
);
  logic sel_edge;
  logic gate_open;
  logic tick_ok;

  always_comb begin
    // polarity 1 watches rising edges / low gate; polarity 0 the opposite
    sel_edge  = pol_i ? rise_i : fall_i;
    gate_open = pol_i ? ~lvl_i : lvl_i;
    tick_ok   = tick64_i & tmr_en_i;
    inc_o     = 1'b0;
    if (acc_en_i) begin
      if (mode_i == MODE_EVENT) inc_o = sel_edge;
      else                      inc_o = tick_ok & gate_open;
    end
    // the trailing edge of the gate coincides with the counted edge polarity
    inp_evt_o = acc_en_i & sel_edge;
  end
endmodule

// File: rtl/pacc_core.sv
module pacc_core
  import pacc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_i,
  input  logic             inp_evt_i,
  input  logic             fast_clr_i,
  input  logic             cnt_rd_i,
  input  logic             cnt_wr_i,
  input  logic [CNT_W-1:0] cnt_wdata_i,
  input  logic             flg_wr_i,
  input  logic [FLG_W-1:0] flg_wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o,
  output logic             inp_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ovf_q, ovf_d;
  logic             inp_q, inp_d;
  logic             wrap;
  logic             fclr;
  logic             ovf_wclr;
  logic             inp_wclr;

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_wr_i)   cnt_d = cnt_wdata_i;
    else if (inc_i) cnt_d = cnt_q + CNT_ONE;

    wrap     = inc_i & ~cnt_wr_i & (cnt_q == CNT_MAX);
    fclr     = fast_clr_i & (cnt_rd_i | cnt_wr_i);
    ovf_wclr = flg_wr_i & flg_wdata_i[FLG_OVF];
    inp_wclr = flg_wr_i & flg_wdata_i[FLG_INP];

    // a new event wins over a clear in the same cycle
    ovf_d = wrap      | (ovf_q & ~fclr & ~ovf_wclr);
    inp_d = inp_evt_i | (inp_q & ~fclr & ~inp_wclr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
      inp_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
      inp_q <= inp_d;
    end
  end

  assign cnt_o = cnt_q;
  assign ovf_o = ovf_q;
  assign inp_o = inp_q;

  // R11: a write lands regardless of a concurrent increment
  a_r11_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr_i |=> cnt_q == $past(cnt_wdata_i));

  // R8: wrap from all ones gives zero and raises the wrap flag
  a_r8_wrap_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !cnt_wr_i && cnt_q == CNT_MAX) |=> (ovf_q && cnt_q == '0));

  // R2: without increment or write the count holds
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc_i && !cnt_wr_i) |=> $stable(cnt_q));

  // R10: fast clear on a read empties both flags when nothing new arrives
  a_r10_fast_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (fast_clr_i && cnt_rd_i && !inc_i && !inp_evt_i) |=> (!ovf_q && !inp_q));

  // R9: write-one clear of the wrap flag
  a_r9_ovf_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (flg_wr_i && flg_wdata_i[FLG_OVF] && !inc_i) |=> !ovf_q);
endmodule

// File: rtl/pacc_top.sv
module pacc_top
  import pacc_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_i,
  input  logic             tick64_i,
  input  logic             tmr_en_i,
  input  logic             acc_en_i,
  input  logic             mode_i,
  input  logic             pol_i,
  input  logic             ovf_ie_i,
  input  logic             inp_ie_i,
  input  logic             fast_clr_i,
  input  logic             cnt_rd_i,
  input  logic             cnt_wr_i,
  input  logic [CNT_W-1:0] cnt_wdata_i,
  input  logic             flg_wr_i,
  input  logic [1:0]       flg_wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_flag_o,
  output logic             inp_flag_o,
  output logic             ovf_irq_o,
  output logic             inp_irq_o,
  output logic             paclk_o
);
  logic       lvl, rise, fall;
  logic       inc, inp_evt;
  pacc_mode_e mode;

  assign mode = pacc_mode_e'(mode_i);

  pacc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_i    (pin_i),
    .lvl_o  (lvl),
    .rise_o (rise),
    .fall_o (fall)
  );

  pacc_qual u_qual (
    .acc_en_i  (acc_en_i),
    .mode_i    (mode),
    .pol_i     (pol_i),
    .tmr_en_i  (tmr_en_i),
    .tick64_i  (tick64_i),
    .lvl_i     (lvl),
    .rise_i    (rise),
    .fall_i    (fall),
    .inc_o     (inc),
    .inp_evt_o (inp_evt)
  );

  pacc_core #(.CNT_W(CNT_W)) u_core (
    .clk         (clk),
    .rst_n       (rst_n),
    .inc_i       (inc),
    .inp_evt_i   (inp_evt),
    .fast_clr_i  (fast_clr_i),
    .cnt_rd_i    (cnt_rd_i),
    .cnt_wr_i    (cnt_wr_i),
    .cnt_wdata_i (cnt_wdata_i),
    .flg_wr_i    (flg_wr_i),
    .flg_wdata_i (flg_wdata_i),
    .cnt_o       (cnt_o),
    .ovf_o       (ovf_flag_o),
    .inp_o       (inp_flag_o)
  );

  assign ovf_irq_o = ovf_flag_o & ovf_ie_i;
  assign inp_irq_o = inp_flag_o & inp_ie_i;
  assign paclk_o   = inc;

  // R7: gated mode without the timer produces no increments
  a_r7_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i && !tmr_en_i && !cnt_wr_i) |=> $stable(cnt_o));

  // R2: disabled accumulator raises no new input flag
  a_r2_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_en_i && !inp_flag_o) |=> !inp_flag_o);

  // R13: every clock-output pulse moves the count by one unless a write intervenes
  a_r13_pulse_step: assert property (@(posedge clk) disable iff (!rst_n)
    (paclk_o && !cnt_wr_i) |=> cnt_o == $past(cnt_o) + CNT_W'(1));
endmodule

// File: tb/pacc_top_tb_top.sv
module pacc_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        pin_i, tick64_i, tmr_en_i, acc_en_i, mode_i, pol_i;
  logic        ovf_ie_i, inp_ie_i, fast_clr_i, cnt_rd_i, cnt_wr_i, flg_wr_i;
  logic [15:0] cnt_wdata_i;
  logic [1:0]  flg_wdata_i;
  logic [15:0] cnt_o;
  logic        ovf_flag_o, inp_flag_o, ovf_irq_o, inp_irq_o, paclk_o;

  int n_run  = 0;
  int n_fail = 0;
  int pk_cnt = 0;

  always #5 clk = ~clk;

  pacc_top dut_i (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .tick64_i(tick64_i),
    .tmr_en_i(tmr_en_i), .acc_en_i(acc_en_i), .mode_i(mode_i), .pol_i(pol_i),
    .ovf_ie_i(ovf_ie_i), .inp_ie_i(inp_ie_i), .fast_clr_i(fast_clr_i),
    .cnt_rd_i(cnt_rd_i), .cnt_wr_i(cnt_wr_i), .cnt_wdata_i(cnt_wdata_i),
    .flg_wr_i(flg_wr_i), .flg_wdata_i(flg_wdata_i), .cnt_o(cnt_o),
    .ovf_flag_o(ovf_flag_o), .inp_flag_o(inp_flag_o), .ovf_irq_o(ovf_irq_o),
    .inp_irq_o(inp_irq_o), .paclk_o(paclk_o)
  );

  always @(negedge clk) if (rst_n && paclk_o) pk_cnt++;

  task automatic chk(input string req, input int got, input int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic set_pin(input logic v);
    pin_i = v; cyc(5);
  endtask

  task automatic tick(input int n);
    repeat (n) begin tick64_i = 1'b1; cyc(1); tick64_i = 1'b0; cyc(1); end
  endtask

  task automatic wr_cnt(input logic [15:0] v);
    cnt_wr_i = 1'b1; cnt_wdata_i = v; cyc(1); cnt_wr_i = 1'b0; cyc(1);
  endtask

  task automatic wr_flg(input logic [1:0] v);
    flg_wr_i = 1'b1; flg_wdata_i = v; cyc(1); flg_wr_i = 1'b0; cyc(1);
  endtask

  initial begin
    #2_000_000;
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int base;
    rst_n = 1'b0; pin_i = 1'b0; tick64_i = 1'b0; tmr_en_i = 1'b1;
    acc_en_i = 1'b0; mode_i = 1'b0; pol_i = 1'b0; ovf_ie_i = 1'b0;
    inp_ie_i = 1'b0; fast_clr_i = 1'b0; cnt_rd_i = 1'b0; cnt_wr_i = 1'b0;
    flg_wr_i = 1'b0; cnt_wdata_i = '0; flg_wdata_i = '0;
    cyc(3);
    @(negedge clk); rst_n = 1'b1;
    cyc(2);
    // R1 reset state
    chk("R1 count", cnt_o, 0);
    chk("R1 flags", {ovf_flag_o, inp_flag_o}, 0);
    chk("R1 irqs", {ovf_irq_o, inp_irq_o}, 0);

    // R2 disabled: edges and ticks ignored
    set_pin(1); set_pin(0); set_pin(1); mode_i = 1'b1; tick(3); set_pin(0);
    chk("R2 count", cnt_o, 0);
    chk("R2 flags", {ovf_flag_o, inp_flag_o}, 0);

    // R3/R4 event sweep: n full pulses then one extra rising edge held
    acc_en_i = 1'b1; mode_i = 1'b0;
    for (int p = 0; p < 2; p++) begin
      for (int n = 1; n <= 6; n++) begin
        pol_i = p[0];
        wr_cnt(16'h0000); wr_flg(2'b11);
        base = pk_cnt;
        for (int k = 0; k < n; k++) begin set_pin(1); set_pin(0); end
        set_pin(1);
        if (p == 1) begin
          chk("R3 rising count", cnt_o, n + 1);
          chk("R13 pulses rising", pk_cnt - base, n + 1);
          chk("R3 inp flag", inp_flag_o, 1);
        end else begin
          chk("R4 falling count", cnt_o, n);
          chk("R13 pulses falling", pk_cnt - base, n);
          chk("R4 inp flag", inp_flag_o, 1);
        end
        set_pin(0);
      end
    end

    // R5/R6 gated sweep
    mode_i = 1'b1;
    for (int p = 0; p < 2; p++) begin
      for (int k = 0; k <= 4; k++) begin
        pol_i = p[0];
        set_pin(p[0]);               // idle = inactive level
        wr_cnt(16'h0000); wr_flg(2'b11);
        tick(3);
        chk(p ? "R6 idle ticks" : "R5 idle ticks", cnt_o, 0);
        set_pin(~p[0]);              // open gate
        chk(p ? "R6 lead edge flag" : "R5 lead edge flag", inp_flag_o, 0);
        base = pk_cnt;
        tick(k);
        set_pin(p[0]);               // close gate
        chk(p ? "R6 gated count" : "R5 gated count", cnt_o, k);
        chk("R13 gated pulses", pk_cnt - base, k);
        chk(p ? "R6 trail flag" : "R5 trail flag", inp_flag_o, 1);
      end
    end

    // R7 gated, timer disabled
    pol_i = 1'b0; set_pin(1); wr_cnt(16'h0010);
    tmr_en_i = 1'b0; tick(4);
    chk("R7 no tick count", cnt_o, 16'h0010);
    tmr_en_i = 1'b1; tick(1);
    chk("R7 tick restored", cnt_o, 16'h0011);

    // R11 write wins over same-cycle increment
    tick64_i = 1'b1; cnt_wr_i = 1'b1; cnt_wdata_i = 16'h1234; cyc(1);
    tick64_i = 1'b0; cnt_wr_i = 1'b0; cyc(1);
    chk("R11 write priority", cnt_o, 16'h1234);
    tick(1);
    chk("R11 count after write", cnt_o, 16'h1235);
    set_pin(0);

    // R8 wrap in event rising mode
    mode_i = 1'b0; pol_i = 1'b1; wr_cnt(16'hFFFE); wr_flg(2'b11);
    set_pin(1); set_pin(0);
    chk("R8 no wrap yet", ovf_flag_o, 0);
    set_pin(1); set_pin(0);
    chk("R8 wrapped count", cnt_o, 0);
    chk("R8 wrap flag", ovf_flag_o, 1);

    // R12 irq gating
    chk("R12 irqs disabled", {ovf_irq_o, inp_irq_o}, 0);
    ovf_ie_i = 1'b1; cyc(1);
    chk("R12 ovf irq", {ovf_irq_o, inp_irq_o}, 2'b10);
    inp_ie_i = 1'b1; cyc(1);
    chk("R12 both irqs", {ovf_irq_o, inp_irq_o}, 2'b11);

    // R9 write-one clear
    wr_flg(2'b00);
    chk("R9 zero write", {ovf_flag_o, inp_flag_o}, 2'b11);
    wr_flg(2'b01);
    chk("R9 clear input", {ovf_flag_o, inp_flag_o}, 2'b10);
    wr_flg(2'b10);
    chk("R9 clear wrap", {ovf_flag_o, inp_flag_o}, 2'b00);
    chk("R12 irqs follow", {ovf_irq_o, inp_irq_o}, 0);

    // R10 fast clear
    wr_cnt(16'hFFFF); set_pin(1); set_pin(0);
    chk("R10 setup flags", {ovf_flag_o, inp_flag_o}, 2'b11);
    cnt_rd_i = 1'b1; cyc(1); cnt_rd_i = 1'b0; cyc(1);
    chk("R10 read no fast", {ovf_flag_o, inp_flag_o}, 2'b11);
    fast_clr_i = 1'b1;
    cnt_rd_i = 1'b1; cyc(1); cnt_rd_i = 1'b0; cyc(1);
    chk("R10 read fast", {ovf_flag_o, inp_flag_o}, 2'b00);
    set_pin(1); set_pin(0);
    chk("R10 inp set again", inp_flag_o, 1);
    wr_cnt(16'h0042);
    chk("R10 write fast", {ovf_flag_o, inp_flag_o}, 2'b00);
    chk("R11 plain write", cnt_o, 16'h0042);
    fast_clr_i = 1'b0;

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule